// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block sits in front of a parallel NOR-style flash controller model and decides whether a program, erase, protect or unprotect request may proceed. It keeps one protection bit per sector. It turns the active-low chip-enable, write-enable and output-enable bus controls into qualified write cycles. It filters short pulses on those controls and refuses commands while the controls already look like a write at power-up. A flag input reports that the reset pin is at the elevated voltage. While that flag is high, the stored protection is bypassed for program and erase, and the stored bits are left as they are.

A write cycle is qualified when the filtered controls show chip-enable low, write-enable low and output-enable high. The cycle completes when filtered write-enable rises while chip-enable stays low and output-enable stays high. At that point the command sequencer's operation code (`op_i`) and the upper address bits (`addr_hi_i`) are evaluated. The result is a one-cycle `grant_o` or a one-cycle `err_o`. A separate status port reads back the stored protection bit of any sector for the identification read path.

The control FSM has three states. ST_LOCKOUT is the power-up state. ST_READ is read-array idle. ST_WCYC means a write cycle is in progress. The transitions are:
- ST_LOCKOUT to ST_READ once the filtered controls are not write-looking.
- ST_READ to ST_WCYC when they become write-looking.
- ST_WCYC to ST_READ when they stop being write-looking. This is an accepted command if write-enable is what rose, and an aborted cycle otherwise.

Top module: `flash_wprot_gate`

## Requirements
- R1: A program (op 00) or erase (op 01) on a sector whose protection bit is set, with `hv_unlock_i` low, gives a one-cycle `err_o` and no `grant_o`.
- R2: A program or erase on an unprotected sector gives exactly one cycle of `grant_o` in the cycle after the accepting edge. `grant_o` and `err_o` are never high together.
- R3: While `hv_unlock_i` is high, program and erase on a protected sector are granted.
- R4: Program, erase and the elevated-voltage flag never alter stored protection. After `hv_unlock_i` falls, a previously protected sector rejects program and erase again.
- R5: A command is accepted only when filtered write-enable rises at the end of a cycle in which chip-enable was low, write-enable low and output-enable high. Chip-enable rising first, or output-enable falling, aborts the cycle with no pulse.
- R6: A change on any control that lasts fewer than GLITCH_CYC (3) sampled clocks is ignored.
- R7: After reset the block is in lockout (`read_array_o` low) and accepts no command. It reaches read-array (`read_array_o` high) only after the filtered controls have been seen not write-looking, and the write-enable rise that ends power-up lockout is not a command.
- R8: Reset clears every protection bit and holds `grant_o` and `err_o` low.
- R9: A protect request (op 10) is always granted and sets the addressed sector's bit.
- R10: An unprotect request (op 11) is refused with `err_o` and changes nothing unless every sector is protected. When granted, it clears the addressed sector's bit.
- R11: `prot_rd_o` combinationally shows the stored bit of the sector selected by `prot_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up / factory reset |
| hv_unlock_i | input | 1 | Reset pin at elevated voltage: temporary unprotect |
| ce_n_i | input | 1 | Chip-enable, active low |
| we_n_i | input | 1 | Write-enable, active low |
| oe_n_i | input | 1 | Output-enable, active low |
| addr_hi_i | input | $clog2(SECTORS) | Upper address bits selecting the sector |
| op_i | input | 2 | Requested operation: 00 program, 01 erase, 10 protect, 11 unprotect |
| prot_sel_i | input | $clog2(SECTORS) | Sector selected for status read |
| prot_rd_o | output | 1 | Stored protection bit of the selected sector |
| grant_o | output | 1 | One-cycle grant of the accepted request |
| err_o | output | 1 | One-cycle refusal of the accepted request |
| read_array_o | output | 1 | FSM is in the read-array idle state |

## Verification
The bench powers up with the controls already in the write pattern. A design without lockout would then turn the first write-enable rise into a command and pulse `grant_o`. It drives two-clock pulses on write-enable and chip-enable, which a filter that is too short would either take as commands or let abort a valid cycle. It raises and drops the elevated-voltage flag around protected programs. A design that rewrote stored bits during the override would stay unprotected afterwards or read back wrong status. It also attempts unprotect with some sectors still open, where a missing all-protected check would clear a bit and grant.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_ERASE  = 2'b01,
        OP_PROT   = 2'b10,
        OP_UNPROT = 2'b11
    } wp_op_e;

    typedef enum logic [1:0] {
        ST_LOCKOUT = 2'b00,
        ST_READ    = 2'b01,
        ST_WCYC    = 2'b10
    } wp_state_e;

    localparam int CTL_CE = 0;
    localparam int CTL_WE = 1;
    localparam int CTL_OE = 2;
    localparam int CTL_N  = 3;

endpackage

// File: rtl/flash_wprot_deglitch.sv
module flash_wprot_deglitch #(
    parameter int   STABLE_CYC = 3,
    parameter logic RST_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(STABLE_CYC - 1);

    logic             filt_q;
    logic [CNT_W-1:0] run_q;

    // output flips only after raw has differed for STABLE_CYC samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= RST_VAL;
            run_q  <= '0;
        end else if (raw_i == filt_q) begin
            run_q  <= '0;
        end else if (run_q == RUN_LAST) begin
            filt_q <= raw_i;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    // R6
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(raw_i) == filt_q && $past(run_q) == RUN_LAST));

endmodule

// File: rtl/flash_wprot_bits.sv
module flash_wprot_bits
    import flash_wprot_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int SEC_W   = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  wp_op_e           op_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic             hv_unlock_i,
    input  logic [SEC_W-1:0] rd_sel_i,
    output logic             rd_prot_o,
    output logic             grant_o,
    output logic             err_o
);
    logic [SECTORS-1:0] prot_q;
    logic [SECTORS-1:0] prot_d;
    logic               all_prot;
    logic               locked;
    logic               ok;
    logic               grant_q;
    logic               err_q;

    assign all_prot = &prot_q;
    assign locked   = prot_q[sec_i] & ~hv_unlock_i;

    always_comb begin
        ok = 1'b0;
        unique case (op_i)
            OP_PROG, OP_ERASE: ok = ~locked;
            OP_PROT:           ok = 1'b1;
            OP_UNPROT:         ok = all_prot;
            default:           ok = 1'b0;
        endcase
    end

    always_comb begin
        prot_d = prot_q;
        if (cmd_valid_i && ok) begin
            if (op_i == OP_PROT)   prot_d[sec_i] = 1'b1;
            if (op_i == OP_UNPROT) prot_d[sec_i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q  <= '0;
            grant_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            prot_q  <= prot_d;
            grant_q <= cmd_valid_i & ok;
            err_q   <= cmd_valid_i & ~ok;
        end
    end

    assign grant_o   = grant_q;
    assign err_o     = err_q;
    assign rd_prot_o = prot_q[rd_sel_i];

    // R1
    locked_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op_i == OP_PROG || op_i == OP_ERASE) && prot_q[sec_i] && !hv_unlock_i)
        |=> (err_o && !grant_o));

    // R3
    hv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (op_i == OP_PROG || op_i == OP_ERASE) && hv_unlock_i) |=> grant_o);

    // R4
    bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_i || op_i == OP_PROG || op_i == OP_ERASE) |=> $stable(prot_q));

    // R10
    unprot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op_i == OP_UNPROT && !(&prot_q)) |=> (err_o && $stable(prot_q)));

endmodule

// File: rtl/flash_wprot_gate.sv
module flash_wprot_gate
    import flash_wprot_pkg::*;
#(
    parameter int SECTORS    = 8,
    parameter int GLITCH_CYC = 3,
    localparam int SEC_W     = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hv_unlock_i,
    input  logic             ce_n_i,
    input  logic             we_n_i,
    input  logic             oe_n_i,
    input  logic [SEC_W-1:0] addr_hi_i,
    input  logic [1:0]       op_i,
    input  logic [SEC_W-1:0] prot_sel_i,
    output logic             prot_rd_o,
    output logic             grant_o,
    output logic             err_o,
    output logic             read_array_o
);
    wp_state_e        state_q;
    wp_state_e        state_d;
    logic [CTL_N-1:0] ctl_raw;
    logic [CTL_N-1:0] ctl_f;
    logic             wr_look;
    logic             accept;

    assign ctl_raw = {oe_n_i, we_n_i, ce_n_i};

    // filters start write-looking so lockout needs a real idle observation
    for (genvar k = 0; k < CTL_N; k++) begin : g_filt
        flash_wprot_deglitch #(
            .STABLE_CYC (GLITCH_CYC),
            .RST_VAL    ((k == CTL_OE) ? 1'b1 : 1'b0)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (ctl_raw[k]),
            .filt_o (ctl_f[k])
        );
    end

    assign wr_look = ~ctl_f[CTL_CE] & ~ctl_f[CTL_WE] & ctl_f[CTL_OE];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKOUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_LOCKOUT: if (!wr_look) state_d = ST_READ;
            ST_READ:    if (wr_look)  state_d = ST_WCYC;
            ST_WCYC: begin
                if (!wr_look) begin
                    state_d = ST_READ;
                    accept  = ctl_f[CTL_WE] & ~ctl_f[CTL_CE] & ctl_f[CTL_OE];
                end
            end
            default: state_d = ST_LOCKOUT;
        endcase
    end

    assign read_array_o = (state_q == ST_READ);

    flash_wprot_bits #(
        .SECTORS (SECTORS),
        .SEC_W   (SEC_W)
    ) bits_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (accept),
        .op_i        (wp_op_e'(op_i)),
        .sec_i       (addr_hi_i),
        .hv_unlock_i (hv_unlock_i),
        .rd_sel_i    (prot_sel_i),
        .rd_prot_o   (prot_rd_o),
        .grant_o     (grant_o),
        .err_o       (err_o)
    );

    // R2
    gnt_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && err_o));

    // R2
    gnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> !grant_o);

    // R5
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || err_o) |-> ($past(state_q) == ST_WCYC && state_q == ST_READ));

    // R7
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKOUT) |=> (!grant_o && !err_o));

endmodule

// File: tb/flash_wprot_gate_tb_top.sv
`timescale 1ns/1ps
module flash_wprot_gate_tb_top;
    localparam int NSEC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hv = 1'b0;
    logic       ce = 1'b0, we = 1'b0, oe = 1'b1;
    logic [2:0] sec_r = '0;
    logic [1:0] op_r = 2'b00;
    logic [2:0] sel_r = '0;
    logic       prot_rd, grant, err, rd_arr;

    int tests = 0, fails = 0, gcnt = 0, ecnt = 0;
    bit done = 0, started = 0;

    always #4 clk = ~clk;

    flash_wprot_gate #(.SECTORS(NSEC), .GLITCH_CYC(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .hv_unlock_i(hv),
        .ce_n_i(ce), .we_n_i(we), .oe_n_i(oe),
        .addr_hi_i(sec_r), .op_i(op_r), .prot_sel_i(sel_r),
        .prot_rd_o(prot_rd), .grant_o(grant), .err_o(err), .read_array_o(rd_arr)
    );

    // behavioural reference: filtered levels, hold counters, mode, protection
    int mf[3] = '{0, 0, 1};
    int mc[3] = '{0, 0, 0};
    int mmode = 0;
    bit mp[NSEC];
    bit mg = 0, me = 0;

    always @(posedge clk) begin
        int raw[3];
        bit look, acc, okv;
        started = 1;
        if (!rst_n) begin
            mf = '{0, 0, 1}; mc = '{0, 0, 0};
            mmode = 0; mg = 0; me = 0;
            foreach (mp[i]) mp[i] = 0;
        end else begin
            raw = '{int'(ce), int'(we), int'(oe)};
            look = (mf[0] == 0 && mf[1] == 0 && mf[2] == 1);
            acc = (mmode == 2 && !look && mf[1] == 1 && mf[0] == 0 && mf[2] == 1);
            if (op_r <= 2'd1) okv = !(mp[sec_r] && !hv);
            else if (op_r == 2'd2) okv = 1;
            else begin
                okv = 1;
                foreach (mp[i]) if (!mp[i]) okv = 0;
            end
            mg = acc && okv;
            me = acc && !okv;
            if (acc && okv && op_r == 2'd2) mp[sec_r] = 1;
            if (acc && okv && op_r == 2'd3) mp[sec_r] = 0;
            if (mmode == 0 && !look) mmode = 1;
            else if (mmode == 1 && look) mmode = 2;
            else if (mmode == 2 && !look) mmode = 1;
            for (int k = 0; k < 3; k++) begin
                if (raw[k] == mf[k]) mc[k] = 0;
                else if (mc[k] == 2) begin mf[k] = raw[k]; mc[k] = 0; end
                else mc[k]++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 grant", int'(grant), int'(mg));
            chk("R1 err", int'(err), int'(me));
            chk("R7 read_array", int'(rd_arr), int'(mmode == 1));
            chk("R11 prot_rd", int'(prot_rd), int'(mp[sel_r]));
            if (grant) gcnt++;
            if (err) ecnt++;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_cmd(input logic [1:0] op, input logic [2:0] s, input int low_len);
        op_r = op; sec_r = s; ce = 0; oe = 1; we = 1; step(5);
        we = 0; step(low_len);
        we = 1; step(5);
        ce = 1; step(5);
    endtask

    task automatic expect_cmd(input string tag, input logic [1:0] op, input logic [2:0] s,
                              input int low_len, input int eg, input int ee);
        int g0, e0;
        g0 = gcnt; e0 = ecnt;
        wr_cmd(op, s, low_len);
        chk({tag, " grants"}, gcnt - g0, eg);
        chk({tag, " errors"}, ecnt - e0, ee);
    endtask

    task automatic rd_bit(input string tag, input logic [2:0] s, input int exp);
        sel_r = s; #1;
        chk(tag, int'(prot_rd), exp);
    endtask

    initial begin
        int g0, e0;
        // power-up with controls already write-looking
        step(4);
        chk("R8 grant in reset", int'(grant), 0);
        chk("R8 err in reset", int'(err), 0);
        for (int s = 0; s < NSEC; s++) rd_bit("R8 R11 reset bit", 3'(s), 0);
        rst_n = 1; step(10);
        chk("R7 lockout holds", int'(rd_arr), 0);
        we = 1; step(6);
        chk("R7 lockout released", int'(rd_arr), 1);
        chk("R7 no command from power-up rise", gcnt + ecnt, 0);
        ce = 1; step(4);

        expect_cmd("R2 program open sector", 2'b00, 3'd2, 5, 1, 0);
        expect_cmd("R9 protect sector 5", 2'b10, 3'd5, 5, 1, 0);
        rd_bit("R9 bit set", 3'd5, 1);
        expect_cmd("R1 program protected", 2'b00, 3'd5, 5, 0, 1);
        expect_cmd("R1 erase protected", 2'b01, 3'd5, 5, 0, 1);
        hv = 1; step(2);
        expect_cmd("R3 program under override", 2'b00, 3'd5, 5, 1, 0);
        expect_cmd("R3 erase under override", 2'b01, 3'd5, 5, 1, 0);
        rd_bit("R4 bit kept during override", 3'd5, 1);
        hv = 0; step(2);
        expect_cmd("R4 protection restored", 2'b00, 3'd5, 5, 0, 1);
        expect_cmd("R10 unprotect refused", 2'b11, 3'd5, 5, 0, 1);
        rd_bit("R10 bit unchanged", 3'd5, 1);

        expect_cmd("R6 two-clock we pulse", 2'b00, 3'd1, 2, 0, 0);
        expect_cmd("R6 three-clock we pulse", 2'b00, 3'd1, 3, 1, 0);

        // R6: chip-enable glitch inside a write does not abort it
        g0 = gcnt; op_r = 2'b00; sec_r = 3'd0; ce = 0; oe = 1; we = 1; step(5);
        we = 0; step(5); ce = 1; step(2); ce = 0; step(4);
        we = 1; step(5); ce = 1; step(5);
        chk("R6 ce glitch ignored", gcnt - g0, 1);

        // R5: chip-enable rises before write-enable
        g0 = gcnt; e0 = ecnt; ce = 0; oe = 1; we = 1; step(5);
        we = 0; step(5); ce = 1; step(5); we = 1; step(5);
        chk("R5 ce-first abort", (gcnt - g0) + (ecnt - e0), 0);

        // R5: output-enable falls during the cycle
        g0 = gcnt; e0 = ecnt; ce = 0; oe = 1; we = 1; step(5);
        we = 0; step(5); oe = 0; step(5); we = 1; step(5);
        ce = 1; oe = 1; step(5);
        chk("R5 oe abort", (gcnt - g0) + (ecnt - e0), 0);

        // R5: output-enable low throughout inhibits
        g0 = gcnt; e0 = ecnt; ce = 0; oe = 0; step(5);
        we = 0; step(5); we = 1; step(5); ce = 1; oe = 1; step(5);
        chk("R5 oe low inhibit", (gcnt - g0) + (ecnt - e0), 0);

        for (int s = 0; s < NSEC; s++) expect_cmd("R9 protect all", 2'b10, 3'(s), 4, 1, 0);
        expect_cmd("R10 unprotect granted", 2'b11, 3'd3, 5, 1, 0);
        rd_bit("R10 bit cleared", 3'd3, 0);
        rd_bit("R11 neighbour kept", 3'd4, 1);
        expect_cmd("R10 second unprotect refused", 2'b11, 3'd4, 5, 0, 1);
        expect_cmd("R2 program reopened sector", 2'b00, 3'd3, 5, 1, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule